// File: doc/BRIEF.md
# Transmit-Diversity Layer Mapper and Precoder

This block sits between a modulation mapper and a resource-grid writer in a downlink transmit chain. It accepts 16-bit complex segments (8-bit I, 8-bit Q) on a valid/ready stream and spreads them over one, two or four layers according to a 3-bit mode code. All layers are then precoded for one, two or four antenna ports in one clock. The two-port case uses a two-symbol space-frequency block code. The four-port case uses two such codes on alternating port pairs. A front buffer collects the segments of one set and holds a complete flag. The mapper answers that flag with a one-cycle clear pulse and loads the precoded slots into an output buffer. The output buffer then releases one slot per accepted transfer, with one 16-bit lane and one valid bit per antenna port.

Back-pressure rules: on the input side, a segment moves on any rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a gathered set waits for the mapper and for as long as the output buffer holds slots. On the output side, a slot is presented while any bit of `out_valid` is high. It is held unchanged until a clock edge with `out_ready` high retires it. `out_ready` is shared by all ports.

Top module: `lm_top`

## Requirements
- R1: `in_data` carries I in bits 15:8 and Q in bits 7:0, both two's complement. The mode codes are 001 single port, 011 one segment on two ports, 101 one segment on four ports, 100 two segments on two ports and 110 four segments on four ports. The mode is sampled together with the first segment of a set, so a later change within that set has no effect on the set.
- R2: A set is one segment for codes 001, 011 and 101, two segments for 100 and four segments for 110. Once the last segment of a set has been accepted, `in_ready` is low until the set has drained.
- R3: When the last segment of a set is accepted at a clock edge, outputs stay idle after that edge. The first slot is presented after the following edge, which is the edge at which the clear pulse loads the output buffer.
- R4: In single-port mode there is one slot. Port 0 carries the segment unchanged and `out_valid` is 0001.
- R5: In the two-port modes (x0 = x1 = the segment for 011) there are two slots with `out_valid` 0011. Slot 0 is port0 = s(x0), port1 = s(-conj(x1)). Slot 1 is port0 = s(x1), port1 = s(conj(x0)).
- R6: In the four-port modes (x0..x3 = the segment for 101) there are four slots. Slots 0 and 1 use ports 0 and 2 (`out_valid` 0101) with x0 and x1 coded as in R5. Slots 2 and 3 use ports 1 and 3 (`out_valid` 1010) with x2 and x3 coded the same way.
- R7: Conjugation negates Q. Negation is two's complement, and -128 maps to +127. The scale s(v) applied in the two- and four-port modes is floor(v*181/256), taken per component after any negation.
- R8: Port p drives `out_data[16p+15:16p]`. Every port whose `out_valid` bit is low drives zero.
- R9: While a slot is presented and `out_ready` is low, `out_data` and `out_valid` hold. Each edge with `out_ready` high advances by exactly one slot.
- R10: `in_ready` is low while any `out_valid` bit is high. It is high again after the edge that retires the last slot. After reset, `in_ready` is high and the outputs are idle.
- R11: The unused mode codes 000, 010 and 111 behave as single-port mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 3 | Layer/port mode code, sampled with the first segment of a set |
| in_valid | input | 1 | Input segment valid |
| in_ready | output | 1 | Block can take a segment |
| in_data | input | 16 | Complex segment {I, Q} |
| out_valid | output | 4 | Per-port valid of the presented slot |
| out_ready | input | 1 | Consumer takes the presented slot |
| out_data | output | 64 | Four 16-bit port lanes, port 0 in the low bits |

## Verification
Each mode is driven with directed segments that place -128 and +127 in I and Q. This separates the saturating negation from plain wrap-around and shows the rounding of the scale on both signs. Random sets over all five valid codes, with random segment values, distinguish the per-port ordering of the block code: a swap of x0 and x1, a missing conjugate or a wrong port pair gives a mismatch on random data. Unused codes and a mode change after the first segment check that the set size and mapping follow the sampled mode. Random `out_ready` patterns check that slots hold under stall, and that input stays blocked until the last slot has left.

// File: rtl/lm_pkg.sv
package lm_pkg;
  localparam int CW       = 8;
  localparam int SEG_W    = 2 * CW;
  localparam int N_PORTS  = 4;
  localparam int N_LAYERS = 4;
  localparam int N_SLOTS  = 4;
  localparam int MODE_W   = 3;
  localparam int CNT_W    = $clog2(N_LAYERS);
  localparam int SL_W     = $clog2(N_SLOTS);
  localparam int SCALE_NUM = 181;
  localparam int SCALE_SH  = 8;
  localparam int PROD_W    = 2 * CW + 1;

  localparam logic [MODE_W-1:0] M_SISO = 3'b001;
  localparam logic [MODE_W-1:0] M_DIV2 = 3'b011;
  localparam logic [MODE_W-1:0] M_DIV4 = 3'b101;
  localparam logic [MODE_W-1:0] M_SPA2 = 3'b100;
  localparam logic [MODE_W-1:0] M_SPA4 = 3'b110;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic signed [CW-1:0] comp_t;

  // number of distinct segments gathered for one set
  function automatic logic [2:0] seg_needed(logic [MODE_W-1:0] m);
    case (m)
      M_SPA2:  return 3'd2;
      M_SPA4:  return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // number of antenna ports, equal to the number of output slots
  function automatic logic [2:0] ports_used(logic [MODE_W-1:0] m);
    case (m)
      M_DIV2, M_SPA2: return 3'd2;
      M_DIV4, M_SPA4: return 3'd4;
      default:        return 3'd1;
    endcase
  endfunction

  function automatic comp_t neg_sat(comp_t v);
    if (v == {1'b1, {(CW-1){1'b0}}}) return {1'b0, {(CW-1){1'b1}}};
    return -v;
  endfunction

  function automatic comp_t scale(comp_t v);
    logic signed [PROD_W-1:0] p;
    p = $signed({{(CW+1){v[CW-1]}}, v}) * $signed(PROD_W'(SCALE_NUM));
    return p[SCALE_SH+CW-1:SCALE_SH];
  endfunction

  function automatic seg_t conj(seg_t s);
    return {s[SEG_W-1:CW], neg_sat(s[CW-1:0])};
  endfunction

  function automatic seg_t neg_conj(seg_t s);
    return {neg_sat(s[SEG_W-1:CW]), s[CW-1:0]};
  endfunction

  function automatic seg_t scale_seg(seg_t s);
    return {scale(s[SEG_W-1:CW]), scale(s[CW-1:0])};
  endfunction
endpackage

// File: rtl/lm_gather.sv
module lm_gather
  import lm_pkg::*;
(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [MODE_W-1:0]                 mode,
  input  logic                              in_valid,
  input  logic [SEG_W-1:0]                  in_data,
  input  logic                              hold,
  input  logic                              clr,
  output logic                              in_ready,
  output logic                              complete,
  output logic [N_LAYERS-1:0][SEG_W-1:0]    segs,
  output logic [MODE_W-1:0]                 set_mode
);
  logic [CNT_W-1:0] cnt;
  logic             full;
  logic [2:0]       need;
  logic             take;

  assign in_ready = !full && !hold;
  assign take     = in_valid && in_ready;
  assign need     = seg_needed((cnt == '0) ? mode : set_mode);
  assign complete = full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      full     <= 1'b0;
      set_mode <= M_SISO;
      segs     <= '0;
    end else begin
      if (clr) full <= 1'b0;
      if (take) begin
        segs[cnt] <= in_data;
        if (cnt == '0) set_mode <= mode;
        if (3'(cnt) == need - 3'd1) begin
          cnt  <= '0;
          full <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lm_precode.sv
module lm_precode
  import lm_pkg::*;
(
  input  logic                                     complete,
  input  logic                                     hold,
  input  logic [N_LAYERS-1:0][SEG_W-1:0]           segs,
  input  logic [MODE_W-1:0]                        set_mode,
  output logic                                     clr,
  output logic [N_SLOTS-1:0][N_PORTS*SEG_W-1:0]    slot_data,
  output logic [N_SLOTS-1:0][N_PORTS-1:0]          slot_mask,
  output logic [2:0]                               slot_cnt
);
  logic [N_LAYERS-1:0][SEG_W-1:0] layer;
  logic [2:0] np;
  logic       shared;

  assign clr = complete && !hold;

  // layer mapping: one segment copied to all layers, or one per layer
  assign np     = ports_used(set_mode);
  assign shared = (seg_needed(set_mode) == 3'd1);

  genvar gl;
  generate
    for (gl = 0; gl < N_LAYERS; gl++) begin : g_layer
      assign layer[gl] = shared ? segs[0] : segs[gl];
    end
  endgenerate

  // precoding: each layer pair becomes two slots on a pair of ports
  always_comb begin
    int pa, pb, s0;
    slot_data = '0;
    slot_mask = '0;
    slot_cnt  = np;
    pa = 0;
    pb = 0;
    s0 = 0;
    if (np == 3'd1) begin
      slot_data[0][SEG_W-1:0] = layer[0];
      slot_mask[0][0]         = 1'b1;
    end else begin
      for (int pr = 0; pr < N_LAYERS / 2; pr++) begin
        if (pr == 0 || np == 3'd4) begin
          pa = pr;
          pb = (np == 3'd4) ? pr + 2 : 1;
          s0 = 2 * pr;
          slot_data[s0][pa*SEG_W +: SEG_W]   = scale_seg(layer[2*pr]);
          slot_data[s0][pb*SEG_W +: SEG_W]   = scale_seg(neg_conj(layer[2*pr+1]));
          slot_data[s0+1][pa*SEG_W +: SEG_W] = scale_seg(layer[2*pr+1]);
          slot_data[s0+1][pb*SEG_W +: SEG_W] = scale_seg(conj(layer[2*pr]));
          slot_mask[s0][pa]   = 1'b1;
          slot_mask[s0][pb]   = 1'b1;
          slot_mask[s0+1][pa] = 1'b1;
          slot_mask[s0+1][pb] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lm_drain.sv
module lm_drain
  import lm_pkg::*;
(
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     load,
  input  logic [N_SLOTS-1:0][N_PORTS*SEG_W-1:0]    slot_data,
  input  logic [N_SLOTS-1:0][N_PORTS-1:0]          slot_mask,
  input  logic [2:0]                               slot_cnt,
  input  logic                                     out_ready,
  output logic                                     busy,
  output logic [N_PORTS-1:0]                       out_valid,
  output logic [N_PORTS*SEG_W-1:0]                 out_data
);
  logic [N_SLOTS-1:0][N_PORTS*SEG_W-1:0] data_q;
  logic [N_SLOTS-1:0][N_PORTS-1:0]       mask_q;
  logic [SL_W-1:0]                       idx;
  logic [SL_W-1:0]                       last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mask_q <= '0;
      idx    <= '0;
      last_q <= '0;
      busy   <= 1'b0;
    end else if (load) begin
      data_q <= slot_data;
      mask_q <= slot_mask;
      last_q <= SL_W'(slot_cnt - 3'd1);
      idx    <= '0;
      busy   <= 1'b1;
    end else if (busy && out_ready) begin
      if (idx == last_q) busy <= 1'b0;
      else               idx  <= idx + 1'b1;
    end
  end

  assign out_valid = busy ? mask_q[idx] : '0;
  assign out_data  = busy ? data_q[idx] : '0;
endmodule

// File: rtl/lm_top.sv
module lm_top
  import lm_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [MODE_W-1:0]          mode,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [SEG_W-1:0]           in_data,
  output logic [N_PORTS-1:0]         out_valid,
  input  logic                       out_ready,
  output logic [N_PORTS*SEG_W-1:0]   out_data
);
  logic                                  complete;
  logic                                  clr;
  logic                                  busy;
  logic [N_LAYERS-1:0][SEG_W-1:0]        segs;
  logic [MODE_W-1:0]                     set_mode;
  logic [N_SLOTS-1:0][N_PORTS*SEG_W-1:0] slot_data;
  logic [N_SLOTS-1:0][N_PORTS-1:0]       slot_mask;
  logic [2:0]                            slot_cnt;

  lm_gather u_gather (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .in_data(in_data), .hold(busy), .clr(clr), .in_ready(in_ready),
    .complete(complete), .segs(segs), .set_mode(set_mode)
  );

  lm_precode u_precode (
    .complete(complete), .hold(busy), .segs(segs), .set_mode(set_mode),
    .clr(clr), .slot_data(slot_data), .slot_mask(slot_mask),
    .slot_cnt(slot_cnt)
  );

  lm_drain u_drain (
    .clk(clk), .rst_n(rst_n), .load(clr), .slot_data(slot_data),
    .slot_mask(slot_mask), .slot_cnt(slot_cnt), .out_ready(out_ready),
    .busy(busy), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/lm_checker.sv
module lm_checker
  import lm_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_ready,
  input logic [N_PORTS-1:0]       out_valid,
  input logic                     out_ready,
  input logic [N_PORTS*SEG_W-1:0] out_data,
  input logic                     complete,
  input logic                     clr
);
  logic [N_PORTS*SEG_W-1:0] idle_bits;

  always_comb begin
    for (int p = 0; p < N_PORTS; p++)
      idle_bits[p*SEG_W +: SEG_W] = {SEG_W{!out_valid[p]}};
  end

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    complete |-> !in_ready); // R2
  AST_CLEAR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (out_valid != '0)); // R3
  AST_VALID_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == 4'b0000) || (out_valid == 4'b0001) || (out_valid == 4'b0011) ||
    (out_valid == 4'b0101) || (out_valid == 4'b1010)); // R6
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_data & idle_bits) == '0); // R8
  AST_HOLD_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ((out_valid != '0) && !out_ready) |=> ($stable(out_data) && $stable(out_valid))); // R9
  AST_BLOCK_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid != '0) |-> !in_ready); // R10
endmodule

bind lm_top lm_checker u_lm_checker (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .complete(complete), .clr(clr)
);

// File: tb/tb_lm_top.sv
module tb_lm_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  mode;
  logic        in_valid;
  logic        in_ready;
  logic [15:0] in_data;
  logic [3:0]  out_valid;
  logic        out_ready;
  logic [63:0] out_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  lm_top dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model built from the requirements
  function automatic logic [7:0] m_neg(logic [7:0] v);
    if (v == 8'h80) return 8'h7f;
    return 8'(0 - v);
  endfunction

  function automatic logic [7:0] m_scl(logic [7:0] v);
    int t;
    t = $signed(v) * 181;
    return 8'(t >>> 8);
  endfunction

  function automatic logic [15:0] m_conj(logic [15:0] s);
    return {s[15:8], m_neg(s[7:0])};
  endfunction

  function automatic logic [15:0] m_nconj(logic [15:0] s);
    return {m_neg(s[15:8]), s[7:0]};
  endfunction

  function automatic logic [15:0] m_sc(logic [15:0] s);
    return {m_scl(s[15:8]), m_scl(s[7:0])};
  endfunction

  function automatic int m_slots(logic [2:0] m);
    case (m)
      3'b011, 3'b100: return 2;
      3'b101, 3'b110: return 4;
      default:        return 1;
    endcase
  endfunction

  function automatic int m_nin(logic [2:0] m);
    case (m)
      3'b100:  return 2;
      3'b110:  return 4;
      default: return 1;
    endcase
  endfunction

  function automatic void m_expect(logic [2:0] m, logic [15:0] s [4], int k,
                                   output logic [63:0] d, output logic [3:0] v);
    logic [15:0] x [4];
    for (int i = 0; i < 4; i++) x[i] = (m_nin(m) == 1) ? s[0] : s[i];
    if (m_slots(m) == 1) begin
      d = {48'h0, x[0]};
      v = 4'b0001;
    end else if (m_slots(m) == 2) begin
      v = 4'b0011;
      if (k == 0) d = {32'h0, m_sc(m_nconj(x[1])), m_sc(x[0])};
      else        d = {32'h0, m_sc(m_conj(x[0])),  m_sc(x[1])};
    end else begin
      case (k)
        0: begin d = {16'h0, m_sc(m_nconj(x[1])), 16'h0, m_sc(x[0])}; v = 4'b0101; end
        1: begin d = {16'h0, m_sc(m_conj(x[0])),  16'h0, m_sc(x[1])}; v = 4'b0101; end
        2: begin d = {m_sc(m_nconj(x[3])), 16'h0, m_sc(x[2]), 16'h0}; v = 4'b1010; end
        default: begin d = {m_sc(m_conj(x[2])), 16'h0, m_sc(x[3]), 16'h0}; v = 4'b1010; end
      endcase
    end
  endfunction

  // ---------------- stimulus tasks, entered and left at a falling edge
  task automatic push(logic [15:0] seg, logic [2:0] m);
    in_valid = 1'b1;
    in_data  = seg;
    mode     = m;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_set(logic [2:0] m, logic [15:0] s [4], bit late_change,
                         bit rand_ready, string tag);
    int n;
    int ns;
    string rq;
    logic [63:0] d;
    logic [3:0]  v;
    n  = m_nin(m);
    ns = m_slots(m);
    if (tag != "") rq = tag;
    else rq = (ns == 1) ? "R4" : (ns == 2) ? "R5" : "R6";
    for (int i = 0; i < n; i++) begin
      push(s[i], (late_change && i > 0) ? 3'b001 : m);
      if (i < n - 1)
        chk(in_ready == 1'b1 && out_valid == 4'b0, "R2", "mid-set gather state",
            {62'h0, in_ready, |out_valid}, 64'h2);
    end
    // cycle after the last acceptance: set complete, nothing presented yet
    chk(in_ready == 1'b0, "R2", "in_ready after full set", {63'h0, in_ready}, 64'h0);
    chk(out_valid == 4'b0, "R3", "idle during clear cycle", {60'h0, out_valid}, 64'h0);
    @(negedge clk);
    chk(out_valid != 4'b0, "R3", "first slot after load edge", {60'h0, out_valid}, 64'h1);
    for (int k = 0; k < ns; k++) begin
      m_expect(m, s, k, d, v);
      forever begin
        out_ready = rand_ready ? 1'($urandom_range(0, 1)) : 1'b1;
        chk(out_data == d, rq, $sformatf("data slot %0d mode %b", k, m), out_data, d);
        chk(out_valid == v, rq, $sformatf("valid slot %0d mode %b", k, m),
            {60'h0, out_valid}, {60'h0, v});
        chk(in_ready == 1'b0, "R10", "input blocked while draining", {63'h0, in_ready}, 64'h0);
        if (out_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
    end
    out_ready = 1'b0;
    chk(in_ready == 1'b1, "R10", "input reopens after drain", {63'h0, in_ready}, 64'h1);
    chk(out_valid == 4'b0 && out_data == 64'h0, "R8", "idle outputs zero", out_data, 64'h0);
  endtask

  initial begin
    logic [15:0] s [4];
    logic [2:0] codes [5];
    codes[0] = 3'b001; codes[1] = 3'b011; codes[2] = 3'b101;
    codes[3] = 3'b100; codes[4] = 3'b110;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; mode = 3'b001; in_valid = 1'b0; in_data = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R10", "reset in_ready", {63'h0, in_ready}, 64'h1);
    chk(out_valid == 4'b0 && out_data == 64'h0, "R10", "reset outputs idle", out_data, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    s[0] = 16'h1234; s[1] = 16'h0; s[2] = 16'h0; s[3] = 16'h0;
    run_set(3'b001, s, 1'b0, 1'b0, "R4");
    s[0] = 16'h8080;
    run_set(3'b011, s, 1'b0, 1'b0, "R7");
    s[0] = 16'h7F80;
    run_set(3'b101, s, 1'b0, 1'b0, "R7");
    s[0] = 16'h80FF; s[1] = 16'h017F;
    run_set(3'b100, s, 1'b0, 1'b0, "R5");
    s[0] = 16'h1122; s[1] = 16'h8033; s[2] = 16'hC47F; s[3] = 16'h0580;
    run_set(3'b110, s, 1'b0, 1'b0, "R6");
    s[0] = 16'hA5C3;
    run_set(3'b000, s, 1'b0, 1'b0, "R11");
    run_set(3'b111, s, 1'b0, 1'b0, "R11");
    run_set(3'b010, s, 1'b0, 1'b0, "R11");
    s[0] = 16'h3C80; s[1] = 16'h9A11; s[2] = 16'h7F7F; s[3] = 16'h8001;
    run_set(3'b110, s, 1'b1, 1'b0, "R1");
    run_set(3'b110, s, 1'b0, 1'b1, "R9");

    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < 4; i++) s[i] = 16'($urandom);
      run_set(codes[$urandom_range(0, 4)], s, 1'b0, 1'b1, "");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule